// File: doc/BRIEF.md
# Interrupt source arbiter and vectorizer

This block sits in front of a simple processor core's exception entry sequencer and decides which pending event is taken next. It watches four sources: a synchronous exception raised by the pipeline (with its vector and a flag saying whether it is a fault), a non-maskable interrupt line, a software-interrupt instruction carrying an immediate vector, and a maskable hardware request whose 4-bit line number comes from an external interrupt controller. The chosen event leaves as a one-cycle take strobe with an 8-bit vector and a 2-bit class tag. The tag tells the sequencer which return address to save: the faulting instruction for a fault, the next instruction for a trap or hardware interrupt.

The block also holds the interrupt-enable flag, a programmable base that is added to the hardware line number, and a busy state for a non-maskable interrupt in progress. While that busy state is set, nothing is taken. A return-from-interrupt pulse ends it and reloads the enable flag from the popped flags value.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the take strobe is 0, the enable flag is 0, the NMI busy state is 0 and the hardware vector base is 32.
- R2: When several sources are eligible in the same accepting cycle, exactly one is taken, in this priority: synchronous exception, then NMI, then software interrupt, then maskable hardware request.
- R3: A taken synchronous exception carries `exc_vec`, with class 0 (fault) when `exc_fault` is 1 and class 1 (trap) otherwise.
- R4: A taken NMI always carries vector 2 and class 3, and it is taken whatever the value of the enable flag.
- R5: From the cycle after an NMI is taken until a return-from-interrupt pulse, `nmi_busy` is 1 and no event of any source is taken; the pulse clears `nmi_busy`.
- R6: A maskable hardware request is ignored while the enable flag is 0; when taken it carries vector (base + line) modulo 256 and class 2.
- R7: A taken software interrupt carries `sw_vec` unchanged (any value 0 to 255) with class 1.
- R8: Enable flag update, highest priority first: a return-from-interrupt pulse loads `iret_ie`; otherwise a clear command or an interrupt-gate report clears it; otherwise a set command sets it. The new value is visible in the next cycle.
- R9: An event is accepted only in a cycle where `entry_ready` is 1 and `take` is 0; `take` rises in the next cycle and lasts exactly one cycle, with `vec` and `cls` valid while it is high.
- R10: A write strobe loads the hardware vector base; the new base applies to requests accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_vec | input | 8 | Exception vector |
| exc_fault | input | 1 | 1: exception is a fault, 0: a trap |
| nmi_req | input | 1 | Non-maskable interrupt request |
| sw_req | input | 1 | Software interrupt request |
| sw_vec | input | 8 | Software interrupt immediate vector |
| hw_req | input | 1 | Maskable hardware request |
| hw_line | input | 4 | Hardware request line number |
| base_wr | input | 1 | Load hardware vector base |
| base_din | input | 8 | New hardware vector base |
| ie_set | input | 1 | Set the enable flag |
| ie_clr | input | 1 | Clear the enable flag |
| gate_int | input | 1 | Sequencer used an interrupt-type gate |
| iret | input | 1 | Return-from-interrupt pulse |
| iret_ie | input | 1 | Enable flag from the popped flags |
| entry_ready | input | 1 | Entry sequencer can accept an event |
| take | output | 1 | One-cycle take strobe |
| vec | output | 8 | Chosen vector |
| cls | output | 2 | Class: 0 fault, 1 trap, 2 hardware interrupt, 3 NMI |
| ie | output | 1 | Current enable flag |
| nmi_busy | output | 1 | NMI handler in progress |

## Verification
A busy state stuck at 1 shows up as a whole run of requests that are never taken, seen at the first request after the return pulse. A busy state that never sets shows up as a software or exception take during an NMI handler, one cycle after the request. A wrong enable flag shows up either as a hardware take that should have been ignored or as a missing one, visible on `ie` in the cycle after the command and on `take` one cycle after the next request. A wrong base or a wrong priority shows up as a wrong `vec` or `cls` in the very strobe that follows the request.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VW = 8,
  parameter int LW = 4,
  parameter logic [VW-1:0] BASE_RST = 8'd32,
  parameter logic [VW-1:0] NMI_VEC = 8'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          exc_fault,
  input  logic          nmi_req,
  input  logic          sw_req,
  input  logic [VW-1:0] sw_vec,
  input  logic          hw_req,
  input  logic [LW-1:0] hw_line,
  input  logic          base_wr,
  input  logic [VW-1:0] base_din,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          gate_int,
  input  logic          iret,
  input  logic          iret_ie,
  input  logic          entry_ready,
  output logic          take,
  output logic [VW-1:0] vec,
  output logic [1:0]    cls,
  output logic          ie,
  output logic          nmi_busy
);
  localparam logic [1:0] C_FAULT = 2'd0;
  localparam logic [1:0] C_TRAP  = 2'd1;
  localparam logic [1:0] C_HW    = 2'd2;
  localparam logic [1:0] C_NMI   = 2'd3;

  logic [VW-1:0] base_q, pvec;
  logic [1:0]    pcls;
  logic          pany, pnmi, go;

  always_comb begin
    pany = 1'b1;
    pnmi = 1'b0;
    pvec = '0;
    pcls = C_TRAP;
    if (exc_req) begin
      pvec = exc_vec;
      pcls = exc_fault ? C_FAULT : C_TRAP;
    end else if (nmi_req) begin
      pvec = NMI_VEC;
      pcls = C_NMI;
      pnmi = 1'b1;
    end else if (sw_req) begin
      pvec = sw_vec;
    end else if (hw_req && ie) begin
      pvec = base_q + VW'(hw_line);
      pcls = C_HW;
    end else begin
      pany = 1'b0;
    end
  end

  assign go = pany && entry_ready && !take && !nmi_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec      <= '0;
      cls      <= C_FAULT;
      ie       <= 1'b0;
      nmi_busy <= 1'b0;
      base_q   <= BASE_RST;
    end else begin
      take <= go;
      if (go) begin
        vec <= pvec;
        cls <= pcls;
      end
      if (go && pnmi)    nmi_busy <= 1'b1;
      else if (iret)     nmi_busy <= 1'b0;
      if (iret)                   ie <= iret_ie;
      else if (ie_clr || gate_int) ie <= 1'b0;
      else if (ie_set)            ie <= 1'b1;
      if (base_wr) base_q <= base_din;
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_nmi_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == C_NMI) |-> (vec == NMI_VEC && nmi_busy));
  p_nmi_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_busy |=> !take);
  p_hw_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == C_HW) |-> $past(ie));
  p_gate_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_int && !iret) |=> !ie);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(entry_ready));
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 0, exc_fault = 0, nmi_req = 0, sw_req = 0, hw_req = 0;
  logic [7:0] exc_vec = 0, sw_vec = 0, base_din = 0;
  logic [3:0] hw_line = 0;
  logic base_wr = 0, ie_set = 0, ie_clr = 0, gate_int = 0, iret = 0, iret_ie = 0;
  logic entry_ready = 1;
  logic take, ie, nmi_busy;
  logic [7:0] vec;
  logic [1:0] cls;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_arbiter uut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic expect_take(input logic [7:0] v, input logic [1:0] c, input string tag);
    exp_q.push_back({c, v});
    tag_q.push_back(tag);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    exc_req = 0; nmi_req = 0; sw_req = 0; hw_req = 0;
    base_wr = 0; ie_set = 0; ie_clr = 0; gate_int = 0; iret = 0;
  endtask

  task automatic gap(); tick(); tick(); endtask

  task automatic no_take_window(input string tag);
    gap();
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && take) begin
      if (exp_q.size() == 0) begin
        chk(0, "unexpected take", {cls, vec}, -1);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({cls, vec} == e, t, {cls, vec}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(take == 0, "R1 take", take, 0);
    chk(ie == 0, "R1 ie", ie, 0);
    chk(nmi_busy == 0, "R1 busy", nmi_busy, 0);
    // R1 base 32 and R6 masking: hw with ie=0 ignored
    hw_req = 1; hw_line = 4'd3; tick(); clear_in();
    no_take_window("R6 masked hw");
    // R8 set
    ie_set = 1; tick(); clear_in();
    chk(ie == 1, "R8 set", ie, 1);
    hw_req = 1; hw_line = 4'd0;
    expect_take(8'd32, 2'd2, "R1 reset base"); tick(); clear_in(); gap();
    hw_req = 1; hw_line = 4'd5;
    expect_take(8'd37, 2'd2, "R6 hw vec"); tick(); clear_in(); gap();
    // R3
    exc_req = 1; exc_vec = 8'd14; exc_fault = 1;
    expect_take(8'd14, 2'd0, "R3 fault"); tick(); clear_in(); gap();
    exc_req = 1; exc_vec = 8'd3; exc_fault = 0;
    expect_take(8'd3, 2'd1, "R3 trap"); tick(); clear_in(); gap();
    // R7
    sw_req = 1; sw_vec = 8'h30;
    expect_take(8'h30, 2'd1, "R7 sw 0x30"); tick(); clear_in(); gap();
    sw_req = 1; sw_vec = 8'hFF;
    expect_take(8'hFF, 2'd1, "R7 sw 255"); tick(); clear_in(); gap();
    // R2 priority ladder
    exc_req = 1; exc_vec = 8'd13; exc_fault = 1; nmi_req = 1; sw_req = 1; sw_vec = 8'h40; hw_req = 1; hw_line = 1;
    expect_take(8'd13, 2'd0, "R2 exc first"); tick(); clear_in(); gap();
    nmi_req = 1; sw_req = 1; hw_req = 1;
    expect_take(8'd2, 2'd3, "R2 nmi second"); tick(); clear_in();
    chk(nmi_busy == 1, "R5 busy set", nmi_busy, 1);
    // R5 blocking
    sw_req = 1; exc_req = 1; hw_req = 1; tick(); tick(); clear_in();
    no_take_window("R5 blocked");
    iret = 1; iret_ie = 1; tick(); clear_in();
    chk(nmi_busy == 0, "R5 busy clear", nmi_busy, 0);
    chk(ie == 1, "R8 iret load", ie, 1);
    sw_req = 1; sw_vec = 8'h41; hw_req = 1; hw_line = 2;
    expect_take(8'h41, 2'd1, "R2 sw third"); tick(); clear_in(); gap();
    hw_req = 1; hw_line = 2;
    expect_take(8'd34, 2'd2, "R2 hw last"); tick(); clear_in(); gap();
    // R4: NMI with ie=0
    ie_clr = 1; tick(); clear_in();
    chk(ie == 0, "R8 clr", ie, 0);
    nmi_req = 1;
    expect_take(8'd2, 2'd3, "R4 nmi unmasked"); tick(); clear_in(); gap();
    iret = 1; iret_ie = 0; ie_set = 1; tick(); clear_in();
    chk(ie == 0, "R8 iret over set", ie, 0);
    ie_set = 1; tick(); clear_in();
    gate_int = 1; tick(); clear_in();
    chk(ie == 0, "R8 gate clear", ie, 0);
    ie_set = 1; ie_clr = 1; tick(); clear_in();
    chk(ie == 0, "R8 clr over set", ie, 0);
    // R10 base write with wrap
    ie_set = 1; base_wr = 1; base_din = 8'hF8; tick(); clear_in();
    hw_req = 1; hw_line = 4'd15;
    expect_take(8'h07, 2'd2, "R10 base wrap"); tick(); clear_in(); gap();
    // R9 ready low
    entry_ready = 0; sw_req = 1; sw_vec = 8'h55; tick(); tick();
    chk(exp_q.size() == 0 && take == 0, "R9 not ready", take, 0);
    expect_take(8'h55, 2'd1, "R9 ready"); entry_ready = 1; tick(); tick(); clear_in();
    no_take_window("R9 single pulse");
    gap();
    chk(exp_q.size() == 0, "queue drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule